// File: doc/BRIEF.md
# Page Group Response Descriptor Decoder

This block sits behind the fetch stage of an invalidation queue and decodes one 128-bit descriptor per handshake. The descriptor arrives as a low and a high 64-bit word. Two descriptor types are handled. A page group response is checked for reserved bits and for a PASID. Its requester ID, PASID and group index are then extracted, and its raw response code is folded into one of three outcomes. The result is presented on a valid/ready output. An invalidation wait descriptor is only checked for legality. Since descriptors are handled strictly in order, a legal wait has no further work to do and just signals completion.

Malformed descriptors raise a one-cycle error pulse that carries a reason code. Any other descriptor type is passed to a separate one-cycle "unhandled" output so that another unit can pick it up. The input is not accepted while a decoded response is waiting to be taken.

Top module: `pgr_desc_decoder`

## Requirements
- R1: The type is `in_lo[3:0]`. Value 9 is a page group response and value 5 is a wait descriptor. Any other type produces a one-cycle `unh_valid` pulse with `unh_type` equal to that type, and no response, error or wait completion.
- R2: For a page group response, a one in any reserved bit makes the descriptor invalid. The reserved bits are `in_lo` bits 11:5 and 63:52, and `in_hi` bits 2:0 and 63:12. The result is an `err_valid` pulse with `err_kind` = 0, and no response is emitted.
- R3: A page group response with no reserved bit set but with PASID-present (`in_lo[4]`) clear is rejected with `err_kind` = 1. The reserved-bit check takes precedence over this one.
- R4: The raw response code `in_lo[15:12]` is folded into `resp_code`: 0 gives 0 (success), 1 gives 1 (invalid request), and every other value gives 2 (failure).
- R5: A legal page group response carries `resp_rid` = `in_lo[31:16]`, `resp_pasid` = `in_lo[51:32]` and `resp_grp` = `in_hi[11:3]`.
- R6: A wait descriptor uses interrupt-flag `in_lo[4]`, status-write `in_lo[5]` and fence `in_lo[6]`. If all three are clear, the result is an error with `err_kind` = 2. Otherwise the result is a single `wait_done` pulse and nothing else, including the fence-only case.
- R7: Every outcome of a descriptor accepted at a clock edge becomes visible right after the next edge. Error, wait and unhandled outcomes are single-cycle pulses, and at most one outcome starts per cycle.
- R8: While `resp_valid` is high and `resp_ready` is low, the response fields hold steady. `in_ready` stays low while `resp_valid` is high.
- R9: After reset, `resp_valid`, `err_valid`, `wait_done` and `unh_valid` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be accepted |
| in_lo | input | 64 | Low descriptor word |
| in_hi | input | 64 | High descriptor word |
| resp_valid | output | 1 | Decoded response available |
| resp_ready | input | 1 | Consumer takes the response |
| resp_rid | output | 16 | Requester ID |
| resp_pasid | output | 20 | PASID |
| resp_grp | output | 9 | Page request group index |
| resp_code | output | 2 | 0 success, 1 invalid request, 2 failure |
| err_valid | output | 1 | Bad descriptor pulse |
| err_kind | output | 2 | 0 reserved bit, 1 no PASID, 2 illegal wait |
| wait_done | output | 1 | Legal wait descriptor completed |
| unh_valid | output | 1 | Unhandled type pulse |
| unh_type | output | 4 | Type of the unhandled descriptor |

## Verification
The assertions tie each outcome to the descriptor words seen at the previous clock edge. They therefore assume that `in_lo` and `in_hi` are stable across the edge at which `in_valid` and `in_ready` are both high, and that `resp_ready` is a clean level. The bench changes all inputs only away from the rising edge. It offers a descriptor only after seeing `in_ready` high, and it drops `in_valid` after one accepted cycle. Backpressure comes from a periodic low pattern on `resp_ready` that is applied only in some phases, so responses are stalled for several cycles as well as taken at once.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int DW       = 64;
  localparam int TYPE_W   = 4;
  localparam int RID_W    = 16;
  localparam int PASID_W  = 20;
  localparam int GRP_W    = 9;
  localparam int RC_W     = 4;

  localparam int PP_BIT    = 4;
  localparam int RC_LSB    = 12;
  localparam int RID_LSB   = 16;
  localparam int PASID_LSB = RID_LSB + RID_W;
  localparam int GRP_LSB   = 3;
  localparam int WAIT_LSB  = 4;
  localparam int WAIT_W    = 3;

  // low word: bits 11:5 between PASID-present and code, bits above the PASID
  localparam logic [DW-1:0] LO_RSVD_MASK =
    ({DW{1'b1}} << (PASID_LSB + PASID_W)) |
    ((({DW{1'b1}} << (PP_BIT + 1))) & ~({DW{1'b1}} << RC_LSB));
  // high word: everything outside the group index
  localparam logic [DW-1:0] HI_RSVD_MASK =
    ~((({DW{1'b1}} << GRP_LSB)) & ~({DW{1'b1}} << (GRP_LSB + GRP_W)));

  typedef enum logic [1:0] {
    RESP_OK     = 2'd0,
    RESP_INVREQ = 2'd1,
    RESP_FAIL   = 2'd2
  } resp_e;

  typedef enum logic [1:0] {
    ERR_RSVD    = 2'd0,
    ERR_NOPASID = 2'd1,
    ERR_WAIT    = 2'd2
  } err_e;

  typedef enum logic [2:0] {
    OUT_NONE = 3'd0,
    OUT_RESP = 3'd1,
    OUT_ERR  = 3'd2,
    OUT_WAIT = 3'd3,
    OUT_UNH  = 3'd4
  } outcome_e;

  typedef struct packed {
    logic [RID_W-1:0]   rid;
    logic [PASID_W-1:0] pasid;
    logic [GRP_W-1:0]   grp;
    resp_e              code;
  } resp_t;

  function automatic resp_e fold_code(input logic [RC_W-1:0] rc);
    if (rc == '0)              return RESP_OK;
    else if (rc == RC_W'(1))   return RESP_INVREQ;
    else                       return RESP_FAIL;
  endfunction

  function automatic logic rsvd_clean(input logic [DW-1:0] lo,
                                      input logic [DW-1:0] hi);
    return ((lo & LO_RSVD_MASK) == '0) && ((hi & HI_RSVD_MASK) == '0);
  endfunction

  function automatic logic wait_legal(input logic [DW-1:0] lo);
    return |lo[WAIT_LSB +: WAIT_W];
  endfunction
endpackage

// File: rtl/pgr_classify.sv
module pgr_classify
  import pgr_pkg::*;
#(
  parameter logic [TYPE_W-1:0] PGR_TYPE  = 4'd9,
  parameter logic [TYPE_W-1:0] WAIT_TYPE = 4'd5
) (
  input  logic [DW-1:0]     lo,
  input  logic [DW-1:0]     hi,
  output outcome_e          outcome,
  output err_e              err_kind,
  output resp_t             resp,
  output logic [TYPE_W-1:0] dtype
);
  always_comb begin
    dtype      = lo[TYPE_W-1:0];
    resp.rid   = lo[RID_LSB +: RID_W];
    resp.pasid = lo[PASID_LSB +: PASID_W];
    resp.grp   = hi[GRP_LSB +: GRP_W];
    resp.code  = fold_code(lo[RC_LSB +: RC_W]);
    err_kind   = ERR_RSVD;
    outcome    = OUT_NONE;
    if (dtype == PGR_TYPE) begin
      if (!rsvd_clean(lo, hi)) begin
        outcome  = OUT_ERR;
        err_kind = ERR_RSVD;
      end else if (!lo[PP_BIT]) begin
        outcome  = OUT_ERR;
        err_kind = ERR_NOPASID;
      end else begin
        outcome  = OUT_RESP;
      end
    end else if (dtype == WAIT_TYPE) begin
      if (wait_legal(lo)) begin
        outcome  = OUT_WAIT;
      end else begin
        outcome  = OUT_ERR;
        err_kind = ERR_WAIT;
      end
    end else begin
      outcome = OUT_UNH;
    end
  end
endmodule

// File: rtl/pgr_resp_hold.sv
module pgr_resp_hold
  import pgr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  resp_t din,
  input  logic  ready,
  output logic  valid,
  output resp_t dout
);
  logic take;
  assign take = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));  // R8
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);  // R8
endmodule

// File: rtl/pgr_event_regs.sv
module pgr_event_regs
  import pgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_err,
  input  err_e              kind_in,
  input  logic              ev_wait,
  input  logic              ev_unh,
  input  logic [TYPE_W-1:0] type_in,
  output logic              err_q,
  output err_e              kind_q,
  output logic              wait_q,
  output logic              unh_q,
  output logic [TYPE_W-1:0] type_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      kind_q <= ERR_RSVD;
      wait_q <= 1'b0;
      unh_q  <= 1'b0;
      type_q <= '0;
    end else begin
      err_q  <= ev_err;
      wait_q <= ev_wait;
      unh_q  <= ev_unh;
      if (ev_err) kind_q <= kind_in;
      if (ev_unh) type_q <= type_in;
    end
  end
endmodule

// File: rtl/pgr_desc_decoder.sv
module pgr_desc_decoder
  import pgr_pkg::*;
#(
  parameter logic [TYPE_W-1:0] PGR_TYPE  = 4'd9,
  parameter logic [TYPE_W-1:0] WAIT_TYPE = 4'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      in_lo,
  input  logic [DW-1:0]      in_hi,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [RID_W-1:0]   resp_rid,
  output logic [PASID_W-1:0] resp_pasid,
  output logic [GRP_W-1:0]   resp_grp,
  output logic [1:0]         resp_code,
  output logic               err_valid,
  output logic [1:0]         err_kind,
  output logic               wait_done,
  output logic               unh_valid,
  output logic [TYPE_W-1:0]  unh_type
);
  outcome_e          outcome;
  err_e              cls_err;
  resp_t             cls_resp;
  logic [TYPE_W-1:0] cls_type;
  resp_t             held;
  err_e              kind_r;
  logic              accept;
  logic              ev_resp, ev_err, ev_wait, ev_unh;

  pgr_classify #(.PGR_TYPE(PGR_TYPE), .WAIT_TYPE(WAIT_TYPE)) u_cls (
    .lo(in_lo), .hi(in_hi), .outcome(outcome), .err_kind(cls_err),
    .resp(cls_resp), .dtype(cls_type)
  );

  assign in_ready = !resp_valid;
  assign accept   = in_valid && in_ready;
  assign ev_resp  = accept && (outcome == OUT_RESP);
  assign ev_err   = accept && (outcome == OUT_ERR);
  assign ev_wait  = accept && (outcome == OUT_WAIT);
  assign ev_unh   = accept && (outcome == OUT_UNH);

  pgr_resp_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(ev_resp), .din(cls_resp),
    .ready(resp_ready), .valid(resp_valid), .dout(held)
  );

  pgr_event_regs u_ev (
    .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .kind_in(cls_err),
    .ev_wait(ev_wait), .ev_unh(ev_unh), .type_in(cls_type),
    .err_q(err_valid), .kind_q(kind_r), .wait_q(wait_done),
    .unh_q(unh_valid), .type_q(unh_type)
  );

  assign resp_rid   = held.rid;
  assign resp_pasid = held.pasid;
  assign resp_grp   = held.grp;
  assign resp_code  = held.code;
  assign err_kind   = kind_r;

  // input-side views used by the properties below
  logic is_pgr, is_wait, rsvd_hit;
  assign is_pgr   = (in_lo[TYPE_W-1:0] == PGR_TYPE);
  assign is_wait  = (in_lo[TYPE_W-1:0] == WAIT_TYPE);
  assign rsvd_hit = ((in_lo & LO_RSVD_MASK) != '0) || ((in_hi & HI_RSVD_MASK) != '0);

  AST_UNHANDLED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_pgr && !is_wait) |=> (unh_valid && !err_valid && !wait_done
      && unh_type == $past(in_lo[TYPE_W-1:0])));  // R1
  AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_pgr && rsvd_hit) |=> (err_valid && err_kind == ERR_RSVD && !resp_valid));  // R2
  AST_NOPASID_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_pgr && !rsvd_hit && !in_lo[PP_BIT]) |=> (err_valid && err_kind == ERR_NOPASID));  // R3
  AST_RESP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_pgr && !rsvd_hit && in_lo[PP_BIT]) |=> (resp_valid && !err_valid
      && resp_rid == $past(in_lo[RID_LSB +: RID_W])
      && resp_grp == $past(in_hi[GRP_LSB +: GRP_W])));  // R5
  AST_WAIT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_wait && in_lo[WAIT_LSB +: WAIT_W] == '0) |=> (err_valid && err_kind == ERR_WAIT));  // R6
  AST_WAIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_wait && in_lo[WAIT_LSB +: WAIT_W] != '0) |=> (wait_done && !err_valid && !unh_valid));  // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_valid, wait_done, unh_valid, $rose(resp_valid)}));  // R7
  AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid || wait_done || unh_valid) && !accept |=> !(err_valid || wait_done || unh_valid));  // R7
  AST_NO_TAKE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !in_ready);  // R8
endmodule

// File: tb/pgr_desc_decoder_tb.sv
module pgr_desc_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, resp_ready = 1;
  logic [63:0] in_lo = '0, in_hi = '0;
  logic in_ready, resp_valid, err_valid, wait_done, unh_valid;
  logic [15:0] resp_rid; logic [19:0] resp_pasid; logic [8:0] resp_grp;
  logic [1:0] resp_code, err_kind; logic [3:0] unh_type;
  int total = 0, bad = 0, ready_mode = 0, cyc = 0;

  always #2 clk = ~clk;

  pgr_desc_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lo(in_lo), .in_hi(in_hi), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_rid(resp_rid), .resp_pasid(resp_pasid), .resp_grp(resp_grp),
    .resp_code(resp_code), .err_valid(err_valid), .err_kind(err_kind),
    .wait_done(wait_done), .unh_valid(unh_valid), .unh_type(unh_type)
  );

  // kind: 0 response, 1 error, 2 wait done, 3 unhandled
  typedef struct {
    int kind; logic [15:0] rid; logic [19:0] pasid; logic [8:0] grp;
    logic [1:0] code; logic [1:0] ek; logic [3:0] ut;
  } item_t;
  item_t q[$];

  function automatic item_t exp_of(input logic [63:0] lo, input logic [63:0] hi);
    item_t e = '{0, 0, 0, 0, 0, 0, 0};
    if (lo[3:0] == 4'd9) begin
      if (lo[11:5] != 0 || lo[63:52] != 0 || hi[2:0] != 0 || hi[63:12] != 0) begin
        e.kind = 1; e.ek = 2'd0;
      end else if (!lo[4]) begin
        e.kind = 1; e.ek = 2'd1;
      end else begin
        e.kind = 0; e.rid = lo[31:16]; e.pasid = lo[51:32]; e.grp = hi[11:3];
        e.code = (lo[15:12] == 0) ? 2'd0 : (lo[15:12] == 1) ? 2'd1 : 2'd2;
      end
    end else if (lo[3:0] == 4'd5) begin
      if (lo[6:4] == 0) begin e.kind = 1; e.ek = 2'd2; end
      else e.kind = 2;
    end else begin
      e.kind = 3; e.ut = lo[3:0];
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin bad++; $display("FAIL %s %s", tag, msg); end
  endtask

  // backpressure applied away from the rising edge
  always @(posedge clk) begin
    cyc++;
    #1 resp_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 5) < 2);
  end

  task automatic send(input logic [63:0] lo, input logic [63:0] hi);
    item_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    e = exp_of(lo, hi);
    q.push_back(e);
    in_valid = 1; in_lo = lo; in_hi = hi;
    @(negedge clk);
    in_valid = 0;
    case (e.kind) // R7: outcome visible one edge after acceptance
      0: check(resp_valid, "R7", $sformatf("resp_valid act=%0b exp=1", resp_valid));
      1: check(err_valid, "R7", $sformatf("err_valid act=%0b exp=1", err_valid));
      2: check(wait_done, "R7", $sformatf("wait_done act=%0b exp=1", wait_done));
      default: check(unh_valid, "R7", $sformatf("unh_valid act=%0b exp=1", unh_valid));
    endcase
  endtask

  task automatic pop_cmp(input int kind);
    item_t e;
    if (q.size() == 0) begin
      check(0, "R7", $sformatf("unexpected outcome act=kind%0d exp=none", kind));
      return;
    end
    e = q.pop_front();
    if (e.kind != kind) begin
      check(0, "R1 R6", $sformatf("outcome act=kind%0d exp=kind%0d", kind, e.kind));
      return;
    end
    case (kind)
      0: check(resp_rid == e.rid && resp_pasid == e.pasid && resp_grp == e.grp && resp_code == e.code,
               "R4 R5", $sformatf("resp act=%h/%h/%h/%0d exp=%h/%h/%h/%0d",
               resp_rid, resp_pasid, resp_grp, resp_code, e.rid, e.pasid, e.grp, e.code));
      1: check(err_kind == e.ek, e.ek == 0 ? "R2" : e.ek == 1 ? "R3" : "R6",
               $sformatf("err_kind act=%0d exp=%0d", err_kind, e.ek));
      2: check(1, "R6", "");
      default: check(unh_type == e.ut, "R1", $sformatf("unh_type act=%0d exp=%0d", unh_type, e.ut));
    endcase
  endtask

  // monitor: scoreboard pops and compares as results appear
  logic pv = 0, pr = 0; logic [46:0] pf = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        check(resp_valid && {resp_rid, resp_pasid, resp_grp, resp_code} == pf, "R8",
              $sformatf("stall hold act=%0b/%h exp=1/%h", resp_valid,
              {resp_rid, resp_pasid, resp_grp, resp_code}, pf));
      if (resp_valid && in_ready) check(0, "R8", "in_ready act=1 exp=0");
      if (resp_valid && resp_ready) pop_cmp(0);
      if (err_valid) pop_cmp(1);
      if (wait_done) pop_cmp(2);
      if (unh_valid) pop_cmp(3);
      pv = resp_valid; pr = resp_ready;
      pf = {resp_rid, resp_pasid, resp_grp, resp_code};
    end
  end

  function automatic logic [63:0] pgr_lo(input logic [3:0] rc, input logic [15:0] rid,
                                         input logic [19:0] pasid, input logic pp);
    return {12'h0, pasid, rid, rc, 7'h0, pp, 4'd9};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R7", "watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !resp_valid && !err_valid && !wait_done && !unh_valid, "R9",
          $sformatf("reset act=%b%b%b%b%b exp=10000", in_ready, resp_valid, err_valid, wait_done, unh_valid));
    // R4 R5: code folding and field extraction
    send(pgr_lo(4'd0, 16'hA55A, 20'h12345, 1), {52'h0, 9'h1A5, 3'b0});
    send(pgr_lo(4'd1, 16'h0001, 20'hFFFFF, 1), {52'h0, 9'h1FF, 3'b0});
    send(pgr_lo(4'd2, 16'hFFFF, 20'h00000, 1), {52'h0, 9'h000, 3'b0});
    send(pgr_lo(4'd15, 16'h1234, 20'h0ABCD, 1), {52'h0, 9'h0F0, 3'b0});
    // R2: reserved bits in each region
    send(pgr_lo(4'd0, 16'h1, 20'h1, 1) | 64'h20, 64'h0);
    send(pgr_lo(4'd0, 16'h1, 20'h1, 1) | 64'h8000_0000_0000_0000, 64'h0);
    send(pgr_lo(4'd0, 16'h1, 20'h1, 1), 64'h1);
    send(pgr_lo(4'd0, 16'h1, 20'h1, 1), 64'h1000);
    // R3: no PASID; reserved check first when both apply
    send(pgr_lo(4'd0, 16'h7, 20'h7, 0), 64'h8);
    send(pgr_lo(4'd0, 16'h7, 20'h7, 0) | 64'h800, 64'h8);
    // R6: wait descriptor legality, fence only
    send(64'h15, 64'h0);
    send(64'h25, 64'h0);
    send(64'h45, 64'h0);
    send(64'h05, 64'h0);
    send(64'hFFFF_0000_0000_0F85, 64'hDEAD);
    // R1: other types
    send(64'h0, 64'h0);
    send(64'hF, 64'h1);
    send(64'h8 | 64'h10, 64'h0);
    // R8: backpressure with mixed traffic
    ready_mode = 1;
    for (int i = 0; i < 120; i++) begin
      logic [63:0] lo, hi;
      lo = pgr_lo(4'($urandom), 16'($urandom), 20'($urandom), ($urandom % 8) != 0);
      hi = {52'h0, 9'($urandom), 3'b0};
      if ($urandom % 6 == 0) lo = lo | (64'h1 << (52 + $urandom % 12));
      if ($urandom % 9 == 0) hi = hi | 64'h4;
      if ($urandom % 7 == 0) lo = {57'($urandom), 3'($urandom), 4'd5};
      if ($urandom % 11 == 0) lo[3:0] = 4'd3;
      send(lo, hi);
    end
    ready_mode = 0;
    for (int i = 0; i < 50 && (q.size() != 0 || resp_valid); i++) @(negedge clk);
    check(q.size() == 0, "R7", $sformatf("pending act=%0d exp=0", q.size()));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule